// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block produces one active-low system reset from three independent fault sources. The sources are a digitized supply-undervoltage flag from an external hysteretic comparator, an active-low manual reset pin, and a single-cycle watchdog-fault strobe. While any source is active, the reset output is held low. After the last source clears, the output stays low for a programmable number of clock ticks and then releases.

The two asynchronous inputs, the supply flag and the manual reset pin, pass through two-flop synchronizers. The manual reset path also has a digital deglitch filter. A manual level is accepted only after it has been stable for a parameterized number of cycles, so short spikes on a long cable or a bouncing push-button do not reach the output. A watchdog strobe is already synchronous to the block clock. It yields one reset pulse of exactly one timeout length. Any new fault that arrives during the timeout restarts the timeout in full. Out of power-on reset the output is low and runs one full timeout before it first goes high.

Top module: `supply_reset_seq`

## Requirements
- R1: While the supply flag `supply_low_i` is 1, `reset_no` is 0. The output falls at the third rising edge after the flag rises, counting the first edge that samples the new level as edge 1.
- R2: A low on `man_rst_ni` that is accepted by the filter drives `reset_no` to 0. This happens at edge MR_FILT_CYC+3, counted from the first edge that samples the low.
- R3: With load value L on `hold_ticks_i`, `reset_no` rises exactly L+1 edges after the last edge that saw a fault. For a supply flag that falls, the rise is at edge L+3, counted from the first edge that samples the fall.
- R4: A load value of 0 still keeps `reset_no` low for one cycle after the last fault.
- R5: A one-cycle watchdog strobe drives `reset_no` low at the next edge. The output stays low for exactly L+1 cycles and rises at edge L+2, counted with the strobe edge as edge 1.
- R6: The filter ignores a manual low that lasts MR_FILT_CYC-1 cycles: `reset_no` stays 1. It accepts a manual low that lasts MR_FILT_CYC cycles.
- R7: A fault that arrives while the timeout is counting reloads the count. `reset_no` then rises L+1 edges after that fault.
- R8: While `rst` is 1, `reset_no` is 0. After `rst` falls, with no fault present, `reset_no` rises L+1 edges after the last edge that saw `rst` high.
- R9: After the manual input returns high, `reset_no` rises at edge MR_FILT_CYC+L+3, counted from the first edge that samples the high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| supply_low_i | input | 1 | Asynchronous flag, 1 = supply below threshold |
| man_rst_ni | input | 1 | Asynchronous manual reset, active low |
| wdog_fault_i | input | 1 | Synchronous single-cycle watchdog-fault strobe |
| hold_ticks_i | input | CNT_W | Timeout load value L, held stable during use |
| reset_no | output | 1 | Registered active-low reset output |

## Verification
The bench builds the block with an 8-bit counter and a 6-cycle manual filter. With a filter this short, both sides of the acceptance boundary (5 and 6 cycles) can be driven directly, and each release edge can be predicted exactly. Because `hold_ticks_i` is a port, the bench can exercise load values of 0, 10 and 20 in one run. This covers the one-cycle minimum extension, ordinary timeouts, and a reload part-way through a countdown, with every expected edge computed from L and the filter length.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef struct packed {
    logic supply_low;
    logic man_low;
    logic wdog;
  } rstseq_src_t;

  function automatic logic any_fault(input rstseq_src_t s);
    return s.supply_low | s.man_low | s.wdog;
  endfunction
endpackage

// File: rtl/rstseq_sync2.sv
module rstseq_sync2 #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic meta_q, stab_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          meta_q <= RST_VAL[i];
          stab_q <= RST_VAL[i];
        end else begin
          meta_q <= d[i];
          stab_q <= meta_q;
        end
      end
      assign q[i] = stab_q;
    end
  endgenerate
endmodule

// File: rtl/rstseq_deglitch.sv
module rstseq_deglitch #(
  parameter int   STABLE_CYC = 40,
  parameter logic RST_LEVEL  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(STABLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

  logic          level_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= RST_LEVEL;
      run_q   <= '0;
    end else if (din != level_q) begin
      if (run_q == LAST) begin
        level_q <= din;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign dout = level_q;

  // R6: the filtered level changes only after a full stable run
  p_flip_after_run_r6: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |-> ($past(run_q) == LAST));

  // R6: the run counter never passes its terminal value
  p_run_bound_r6: assert property (@(posedge clk) disable iff (rst)
    run_q <= LAST);
endmodule

// File: rtl/rstseq_hold_timer.sv
module rstseq_hold_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault,
  input  logic [CNT_W-1:0] load,
  output logic             rst_n_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             rst_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= load;
      rst_n_q <= 1'b0;
    end else if (fault) begin
      cnt_q   <= load;
      rst_n_q <= 1'b0;
    end else if (!rst_n_q) begin
      if (cnt_q == '0) rst_n_q <= 1'b1;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign rst_n_o = rst_n_q;

  // R1: a fault seen at an edge leaves the output low after it
  p_fault_holds_low_r1: assert property (@(posedge clk) disable iff (rst)
    fault |=> !rst_n_q);

  // R3: release happens only from an exhausted count with no fault
  p_release_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_q) |-> ($past(cnt_q) == '0 && !$past(fault)));

  // R3: a quiet countdown decreases by exactly one per cycle
  p_count_down_r3: assert property (@(posedge clk) disable iff (rst)
    (!rst_n_q && !fault && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
  import rstseq_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MR_FILT_CYC = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             supply_low_i,
  input  logic             man_rst_ni,
  input  logic             wdog_fault_i,
  input  logic [CNT_W-1:0] hold_ticks_i,
  output logic             reset_no
);
  localparam int N_ASYNC = 2;

  logic [N_ASYNC-1:0] async_raw, async_s;
  logic               man_low_f;
  rstseq_src_t        src;

  assign async_raw = {~man_rst_ni, supply_low_i};

  rstseq_sync2 #(.WIDTH(N_ASYNC), .RST_VAL('0)) u_sync (
    .clk(clk), .rst(rst), .d(async_raw), .q(async_s)
  );

  rstseq_deglitch #(.STABLE_CYC(MR_FILT_CYC), .RST_LEVEL(1'b0)) u_mr_filt (
    .clk(clk), .rst(rst), .din(async_s[1]), .dout(man_low_f)
  );

  always_comb begin
    src.supply_low = async_s[0];
    src.man_low    = man_low_f;
    src.wdog       = wdog_fault_i;
  end

  rstseq_hold_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .fault(any_fault(src)),
    .load(hold_ticks_i), .rst_n_o(reset_no)
  );

  // R1: a synchronized supply fault forces the output low next cycle
  p_supply_low_r1: assert property (@(posedge clk) disable iff (rst)
    async_s[0] |=> !reset_no);

  // R2: an accepted manual low forces the output low next cycle
  p_manual_low_r2: assert property (@(posedge clk) disable iff (rst)
    man_low_f |=> !reset_no);

  // R5: a watchdog strobe forces the output low next cycle
  p_wdog_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    wdog_fault_i |=> !reset_no);
endmodule

// File: tb/supply_reset_seq_test.sv
`timescale 1ns/1ps
module supply_reset_seq_test;
  localparam int CNT_W = 8;
  localparam int FILT  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_low = 1'b0;
  logic man_n = 1'b1;
  logic wdog = 1'b0;
  logic [CNT_W-1:0] ticks = 8'd10;
  logic reset_no;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  supply_reset_seq #(.CNT_W(CNT_W), .MR_FILT_CYC(FILT)) uut (
    .clk(clk), .rst(rst), .supply_low_i(supply_low), .man_rst_ni(man_n),
    .wdog_fault_i(wdog), .hold_ticks_i(ticks), .reset_no(reset_no)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // edges (sampled just after) until reset_no equals want; -1 if never
  task automatic edges_until(input logic want, input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); @(negedge clk);
      if (reset_no === want) begin n = i; return; end
    end
  endtask

  task automatic settle_high();
    int n;
    edges_until(1'b1, 300, n);
  endtask

  task automatic t_power_on();
    int n;
    ticks = 8'd10;
    repeat (3) @(negedge clk);
    check(reset_no === 1'b0, "R8 low in reset", int'(reset_no), 0);
    rst = 1'b0;
    edges_until(1'b1, 100, n);
    check(n == 11, "R8 first release", n, 11);
  endtask

  task automatic t_supply();
    int n;
    bit held = 1'b1;
    @(negedge clk); supply_low = 1'b1;
    edges_until(1'b0, 20, n);
    check(n == 3, "R1 assert latency", n, 3);
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); @(negedge clk);
      if (reset_no !== 1'b0) held = 1'b0;
    end
    check(held, "R1 held while flag set", int'(held), 1);
    supply_low = 1'b0;
    edges_until(1'b1, 100, n);
    check(n == 13, "R3 release after supply clears", n, 13);
  endtask

  task automatic wdog_strobe(output int n);
    @(negedge clk); wdog = 1'b1;
    @(posedge clk); @(negedge clk); wdog = 1'b0;
    check(reset_no === 1'b0, "R5 low after strobe", int'(reset_no), 0);
    edges_until(1'b1, 100, n);
    if (n > 0) n = n + 1;
  endtask

  task automatic t_zero_load();
    int n;
    ticks = 8'd0;
    wdog_strobe(n);
    check(n == 2, "R4 zero load one-cycle extension", n, 2);
  endtask

  task automatic t_wdog();
    int n;
    ticks = 8'd20;
    wdog_strobe(n);
    check(n == 22, "R5 watchdog pulse length", n, 22);
  endtask

  task automatic t_manual();
    int n;
    ticks = 8'd10;
    @(negedge clk); man_n = 1'b0;
    edges_until(1'b0, 50, n);
    check(n == FILT + 3, "R2 manual assert latency", n, FILT + 3);
    repeat (4) @(negedge clk);
    man_n = 1'b1;
    edges_until(1'b1, 100, n);
    check(n == FILT + 10 + 3, "R9 manual release timing", n, FILT + 13);
  endtask

  task automatic t_glitch();
    int n;
    bit stayed = 1'b1;
    @(negedge clk); man_n = 1'b0;
    repeat (FILT - 1) @(negedge clk);
    man_n = 1'b1;
    for (int i = 0; i < 3 * FILT; i++) begin
      @(posedge clk); @(negedge clk);
      if (reset_no !== 1'b1) stayed = 1'b0;
    end
    check(stayed, "R6 short manual pulse ignored", int'(stayed), 1);
    @(negedge clk); man_n = 1'b0;
    repeat (FILT) @(negedge clk);
    man_n = 1'b1;
    edges_until(1'b0, 20, n);
    check(n > 0, "R6 full-length manual pulse accepted", n, 1);
    settle_high();
  endtask

  task automatic t_reload();
    int n;
    bit low = 1'b1;
    ticks = 8'd10;
    @(negedge clk); supply_low = 1'b1;
    repeat (5) @(negedge clk);
    supply_low = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); @(negedge clk);
      if (reset_no !== 1'b0) low = 1'b0;
    end
    check(low, "R7 still counting before reload", int'(low), 1);
    wdog_strobe(n);
    check(n == 12, "R7 reload restarts timeout", n, 12);
  endtask

  initial begin
    t_power_on();
    t_supply();
    t_zero_load();
    t_wdog();
    t_manual();
    t_glitch();
    t_reload();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule